// File: doc/BRIEF.md
# Margining DAC Code Limiter

This block stands between the firmware-visible margining registers and an 8-bit margining DAC. Software writes a requested DAC code, a lower bound, an upper bound and a two-bit range select. The range select picks one of four midcode offsets: 0.6 V, 0.8 V, 1.0 V or 1.25 V. The block forces the requested code into the inclusive window between the two bounds. It drives the result to the DAC and passes the range select alongside it. The code is unsigned and the output voltage is linear in it. Code 0x7F sits at the chosen offset, with 128 codes above it and 127 below.

A second safety feature exists. If the lower bound is programmed above the upper bound, the DAC output buffer enable is withdrawn whatever code is requested, so the buffer is three-stated. Reset values leave the limits inverted, so the buffer stays off until sensible limits arrive. At power-up a one-cycle boot strobe copies all four values at once from nonvolatile storage. After that, ordinary writes may change any single register. A read port returns the raw, unclamped register contents, so software can tell when its request was clipped.

Top module: `mdac_limiter`

## Requirements
- R1: While reset is high and on the cycle after it, the registers hold request 0x7F, lower bound 0xFF, upper bound 0x00 and range select 0. The outputs show `dac_en` 0, `dac_code` 0x7F and `dac_range` 0.
- R2: A cycle with `boot_load` high copies `boot_req`, `boot_lo`, `boot_hi` and `boot_sel` into the four registers at once. If a write is requested in the same cycle, the load takes priority and the write is dropped.
- R3: A write with `wr_en` high changes only the addressed register. The addresses are: 0 for the request, 1 for the lower bound, 2 for the upper bound and 3 for the range select, which takes `wr_data[1:0]`.
- R4: When lower ≤ request ≤ upper (both ends inclusive) and lower ≤ upper, `dac_code` equals the request.
- R5: When lower ≤ upper, a request below the lower bound yields the lower bound, and a request above the upper bound yields the upper bound.
- R6: When lower > upper, `dac_en` is 0 and `dac_code` is parked at 0x7F, whatever the request.
- R7: `dac_en` is 1 exactly when lower ≤ upper.
- R8: `dac_code`, `dac_en` and `dac_range` are registered. They reflect a register change one clock after the edge that made it.
- R9: `rd_data` is registered. One clock after `rd_addr` is presented, it returns the raw contents of the addressed register, with the range select zero-extended.
- R10: `dac_range` follows the range select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered raw register contents |
| boot_load | input | 1 | One-cycle bulk load from nonvolatile storage |
| boot_req | input | 8 | Startup request code |
| boot_lo | input | 8 | Startup lower bound |
| boot_hi | input | 8 | Startup upper bound |
| boot_sel | input | 2 | Startup range select |
| dac_code | output | 8 | Clamped code to the DAC |
| dac_range | output | 2 | Midcode offset select to the DAC |
| dac_en | output | 1 | DAC output buffer enable |

## Verification
Some rules are checked by the assertions on every cycle. These are: the enable is never high unless the applied code lies inside the bounds of the previous cycle, inverted bounds always withdraw the enable, an in-window request passes unchanged, a boot strobe lands all four values, and the range output tracks its register. Other behaviour can only be shown by the bench's scenarios. That covers the exact reset values, load priority over a colliding write, a write leaving the other registers untouched, the read-back of raw values while the applied code is clipped, and the exact clamp results at both window edges.

// File: rtl/mdac_pkg.sv
package mdac_pkg;
  typedef enum logic [1:0] {
    SLOT_REQ = 2'd0,
    SLOT_LO  = 2'd1,
    SLOT_HI  = 2'd2,
    SLOT_SEL = 2'd3
  } slot_e;
endpackage

// File: rtl/mdac_regfile.sv
module mdac_regfile
  import mdac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              boot_load,
  input  logic [CODE_W-1:0] boot_req,
  input  logic [CODE_W-1:0] boot_lo,
  input  logic [CODE_W-1:0] boot_hi,
  input  logic [SEL_W-1:0]  boot_sel,
  output logic [CODE_W-1:0] req_q,
  output logic [CODE_W-1:0] lo_q,
  output logic [CODE_W-1:0] hi_q,
  output logic [SEL_W-1:0]  sel_q
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'((1 << (CODE_W-1)) - 1);
  localparam logic [CODE_W-1:0] ALL_ONES = {CODE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= MID_CODE;
      lo_q  <= ALL_ONES;
      hi_q  <= '0;
      sel_q <= '0;
    end else if (boot_load) begin
      req_q <= boot_req;
      lo_q  <= boot_lo;
      hi_q  <= boot_hi;
      sel_q <= boot_sel;
    end else if (wr_en) begin
      unique case (slot_e'(wr_addr))
        SLOT_REQ: req_q <= wr_data;
        SLOT_LO:  lo_q  <= wr_data;
        SLOT_HI:  hi_q  <= wr_data;
        SLOT_SEL: sel_q <= wr_data[SEL_W-1:0];
        default:  ;
      endcase
    end
  end

  // R2
  boot_copy_chk: assert property (@(posedge clk) disable iff (rst)
    $past(boot_load) && !$past(rst) |->
      (req_q == $past(boot_req)) && (lo_q == $past(boot_lo)) &&
      (hi_q == $past(boot_hi)) && (sel_q == $past(boot_sel)));

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(boot_load) && !$past(wr_en) && !$past(rst) |->
      $stable(req_q) && $stable(lo_q) && $stable(hi_q) && $stable(sel_q));
endmodule

// File: rtl/mdac_clamp.sv
module mdac_clamp #(
  parameter int CODE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] req_q,
  input  logic [CODE_W-1:0] lo_q,
  input  logic [CODE_W-1:0] hi_q,
  input  logic [SEL_W-1:0]  sel_q,
  output logic [CODE_W-1:0] dac_code,
  output logic [SEL_W-1:0]  dac_range,
  output logic              dac_en
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'((1 << (CODE_W-1)) - 1);

  logic              bounds_ok;
  logic [CODE_W-1:0] code_n;

  always_comb begin
    bounds_ok = (lo_q <= hi_q);
    if (!bounds_ok)         code_n = MID_CODE;
    else if (req_q < lo_q)  code_n = lo_q;
    else if (req_q > hi_q)  code_n = hi_q;
    else                    code_n = req_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code  <= MID_CODE;
      dac_range <= '0;
      dac_en    <= 1'b0;
    end else begin
      dac_code  <= code_n;
      dac_range <= sel_q;
      dac_en    <= bounds_ok;
    end
  end

  // R5
  in_window_chk: assert property (@(posedge clk) disable iff (rst)
    dac_en |-> (dac_code >= $past(lo_q)) && (dac_code <= $past(hi_q)));

  // R6
  lock_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(lo_q) > $past(hi_q)) && !$past(rst) |-> !dac_en && (dac_code == MID_CODE));

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(lo_q) <= $past(req_q)) && ($past(req_q) <= $past(hi_q))
      |-> dac_en && (dac_code == $past(req_q)));

  // R10
  range_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dac_range == $past(sel_q));
endmodule

// File: rtl/mdac_readback.sv
module mdac_readback
  import mdac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rd_addr,
  input  logic [CODE_W-1:0] req_q,
  input  logic [CODE_W-1:0] lo_q,
  input  logic [CODE_W-1:0] hi_q,
  input  logic [SEL_W-1:0]  sel_q,
  output logic [CODE_W-1:0] rd_data
);
  logic [CODE_W-1:0] pick;

  always_comb begin
    unique case (slot_e'(rd_addr))
      SLOT_REQ: pick = req_q;
      SLOT_LO:  pick = lo_q;
      SLOT_HI:  pick = hi_q;
      SLOT_SEL: pick = CODE_W'(sel_q);
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= pick;
  end

  // R9
  raw_request_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(rd_addr) == 2'd0) |-> rd_data == $past(req_q));
endmodule

// File: rtl/mdac_limiter.sv
module mdac_limiter #(
  parameter int CODE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [CODE_W-1:0] rd_data,
  input  logic              boot_load,
  input  logic [CODE_W-1:0] boot_req,
  input  logic [CODE_W-1:0] boot_lo,
  input  logic [CODE_W-1:0] boot_hi,
  input  logic [SEL_W-1:0]  boot_sel,
  output logic [CODE_W-1:0] dac_code,
  output logic [SEL_W-1:0]  dac_range,
  output logic              dac_en
);
  logic [CODE_W-1:0] req_q, lo_q, hi_q;
  logic [SEL_W-1:0]  sel_q;

  mdac_regfile #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .boot_load(boot_load), .boot_req(boot_req), .boot_lo(boot_lo),
    .boot_hi(boot_hi), .boot_sel(boot_sel),
    .req_q(req_q), .lo_q(lo_q), .hi_q(hi_q), .sel_q(sel_q)
  );

  mdac_clamp #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_clamp (
    .clk(clk), .rst(rst),
    .req_q(req_q), .lo_q(lo_q), .hi_q(hi_q), .sel_q(sel_q),
    .dac_code(dac_code), .dac_range(dac_range), .dac_en(dac_en)
  );

  mdac_readback #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr),
    .req_q(req_q), .lo_q(lo_q), .hi_q(hi_q), .sel_q(sel_q),
    .rd_data(rd_data)
  );
endmodule

// File: tb/test_mdac_limiter.sv
module test_mdac_limiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       boot_load = 1'b0;
  logic [7:0] boot_req = '0, boot_lo = '0, boot_hi = '0;
  logic [1:0] boot_sel = '0;
  logic [7:0] dac_code;
  logic [1:0] dac_range;
  logic       dac_en;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_req, m_lo, m_hi;
  logic [1:0] m_sel;

  always #5 clk = ~clk;

  mdac_limiter i_mdac_limiter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .boot_load(boot_load),
    .boot_req(boot_req), .boot_lo(boot_lo), .boot_hi(boot_hi), .boot_sel(boot_sel),
    .dac_code(dac_code), .dac_range(dac_range), .dac_en(dac_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code();
    if (m_lo > m_hi) return 8'h7F;
    if (m_req < m_lo) return m_lo;
    if (m_req > m_hi) return m_hi;
    return m_req;
  endfunction

  // outputs settle one edge after the register edge; sample at the negedge after it
  task automatic check_outputs(input string tag);
    check({tag, " code"}, dac_code, exp_code());
    check({tag, " en"}, dac_en, (m_lo <= m_hi) ? 1 : 0);
    check({tag, " range"}, dac_range, m_sel);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: m_req = d;
      2'd1: m_lo = d;
      2'd2: m_hi = d;
      default: m_sel = d[1:0];
    endcase
    @(negedge clk);
  endtask

  task automatic do_read(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    // R1
    check("R1 code", dac_code, 8'h7F);
    check("R1 en", dac_en, 0);
    check("R1 range", dac_range, 0);
    m_req = 8'h7F; m_lo = 8'hFF; m_hi = 8'h00; m_sel = 2'd0;
    do_read(2'd0, 8'h7F, "R1 req");
    do_read(2'd1, 8'hFF, "R1 lo");
    do_read(2'd2, 8'h00, "R1 hi");
    do_read(2'd3, 0, "R1 sel");
  endtask

  task automatic t_boot();
    // R2 with colliding write that must be dropped
    @(negedge clk);
    boot_load = 1'b1; boot_req = 8'h90; boot_lo = 8'h40; boot_hi = 8'hC0; boot_sel = 2'd2;
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h11;
    @(negedge clk);
    boot_load = 1'b0; wr_en = 1'b0;
    m_req = 8'h90; m_lo = 8'h40; m_hi = 8'hC0; m_sel = 2'd2;
    // R8: outputs not yet updated one edge after the load
    check("R8 code lag", dac_code, 8'h7F);
    check("R8 en lag", dac_en, 0);
    @(negedge clk);
    check_outputs("R2 boot");
    do_read(2'd0, 8'h90, "R2 req wins over write");
    do_read(2'd3, 2, "R2 sel");
  endtask

  task automatic t_window();
    do_write(2'd0, 8'h40); check_outputs("R4 at lower edge");
    do_write(2'd0, 8'hC0); check_outputs("R4 at upper edge");
    do_write(2'd0, 8'h7F); check_outputs("R4 mid");
    do_write(2'd0, 8'h3F); check_outputs("R5 below");
    check("R5 below value", dac_code, 8'h40);
    do_write(2'd0, 8'hFF); check_outputs("R5 above");
    check("R5 above value", dac_code, 8'hC0);
    // R9: raw request read back while clipped
    do_read(2'd0, 8'hFF, "R9 raw req");
    do_write(2'd0, 8'h00); check_outputs("R5 zero");
  endtask

  task automatic t_write_isolated();
    // R3: only lower bound changes
    do_write(2'd1, 8'h10);
    do_read(2'd0, 8'h00, "R3 req untouched");
    do_read(2'd2, 8'hC0, "R3 hi untouched");
    do_read(2'd1, 8'h10, "R3 lo written");
    check_outputs("R3 after lo write");
    do_write(2'd3, 8'hF1);
    check_outputs("R10 range");
    do_read(2'd3, 1, "R9 sel zero-extended");
  endtask

  task automatic t_lockout();
    // R6 / R7
    do_write(2'd0, 8'h50);
    do_write(2'd1, 8'hA0);
    do_write(2'd2, 8'h9F);
    check("R6 en off", dac_en, 0);
    check("R6 parked", dac_code, 8'h7F);
    do_write(2'd0, 8'hA0);
    check_outputs("R6 request ignored");
    do_write(2'd2, 8'hA0);
    check("R7 equal bounds en", dac_en, 1);
    check_outputs("R7 single-code window");
  endtask

  initial begin : wd
    repeat (5000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_boot();
    t_window();
    t_write_isolated();
    t_lockout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule